// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts one 128-bit block under AES-128. It builds a single round unit and uses it again for every round. The round unit performs the byte substitution, the row shift and the column mix, followed by the key XOR. Key expansion happens outside the block. The block takes the whitening key and ten round keys as one flat bus. It encrypts only; decryption and the longer key sizes are outside its scope.

A one-cycle `start` pulse in the idle state does three things:
- It XORs the plaintext with the whitening key.
- It loads the result into the state register.
- It latches the 2-bit `seed`.

An eleven-state sequencer then counts out ten rounds and controls three selectors:
- The state input selector picks either the fresh input or the column-mix feedback.
- The round-key selector picks which of the ten keys the round uses.
- The output selector holds zero until the final result is ready.

The latched seed picks one of four fixed orders in which rounds 1 to 9 take their keys. Mode 0 is the standard cipher. The final round always skips the column mix and always uses key 10. The ciphertext appears together with a one-cycle `done` pulse.

Top module: `aes_iter_core`

## Requirements
- R1: A synchronous active-high `rst` returns the core to idle with `done` low and `blk_out` zero, and it abandons any block in progress, so no `done` follows.
- R2: A `start` pulse accepted at clock edge 0 loads `blk_in ^ key_init`. `done` goes high after edge 10, so the result arrives exactly ten cycles after the accepting edge.
- R3: `done` is high for exactly one cycle per block.
- R4: Whenever `done` is low, `blk_out` reads all zeros.
- R5: Seed 0 uses round key k in round k and matches the standard AES-128 result. For example, plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a. Round key k (1 to 10) sits at `key_rounds[128*k-1 -: 128]`. Byte 0 of a block is bits [127:120], and byte 4c+r is row r of column c.
- R6: Seed 1 uses key 10-r in round r, for r from 1 to 9.
- R7: Seed 2 uses key r+1 in rounds 1 to 8 and key 1 in round 9.
- R8: Seed 3 uses keys 1, 3, 5, 7, 9, 2, 4, 6, 8 in rounds 1 to 9.
- R9: Under every seed, the final round omits the column mix and XORs the shifted state with key 10. A change to one bit of key 10 therefore changes only the same bit of the ciphertext.
- R10: A `start` pulse that arrives while a block is in progress is ignored. The current block finishes unchanged and on time.
- R11: The seed is sampled only at the accepting edge. Changing `seed` during a block has no effect on that block's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; accepted only when idle |
| seed | input | 2 | Selects the round-key ordering mode |
| blk_in | input | 128 | Plaintext block |
| key_init | input | 128 | Whitening key applied at load |
| key_rounds | input | 1280 | Round keys 1 to 10, key k at bits [128*k-1 -: 128] |
| blk_out | output | 128 | Ciphertext while `done` is high, otherwise zero |
| done | output | 1 | One-cycle flag marking a valid ciphertext |

## Verification
The standard known-answer vector under seed 0 fixes the substitution, shift, mix and final-round wiring against a value that needs no model. It also confirms the bench's own key expansion. Sweeps of random plaintexts under all four seeds, compared with an independently written model, show whether each mode's key order is followed. The model's key order for each mode is a plain list. A single-bit flip of key 10 shows that the final round has no column mix and that it takes key 10 regardless of seed. Starts and seed changes injected mid-block, together with a reset mid-block, show that nothing but an idle-state start begins or alters a block.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
  localparam int BLK   = 128;
  localparam int NB    = BLK / 8;
  localparam int NCOL  = 4;
  localparam int NRND  = 10;
  localparam int KIW   = $clog2(NRND + 1);

  typedef enum logic [1:0] {ORD_STD, ORD_REV, ORD_ROT, ORD_ODD} ord_mode_t;

  // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // inverse as a^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox8(input logic [7:0] a);
    logic [7:0] b, s;
    b = gf_inv(a);
    for (int i = 0; i < 8; i++)
      s[i] = b[i] ^ b[(i + 4) % 8] ^ b[(i + 5) % 8] ^ b[(i + 6) % 8] ^ b[(i + 7) % 8];
    return s ^ 8'h63;
  endfunction

  function automatic logic [BLK-1:0] shift_rows(input logic [BLK-1:0] s);
    logic [BLK-1:0] o;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < 4; r++)
        o[BLK-1-8*(4*c+r) -: 8] = s[BLK-1-8*(4*((c+r)%NCOL)+r) -: 8];
    return o;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] x);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = x;
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  // key number used in round r; final round and idle pass r through
  function automatic logic [KIW-1:0] key_for(input ord_mode_t m, input logic [KIW-1:0] r);
    logic [KIW:0] d;
    d = {1'b0, r} << 1;
    if (r == KIW'(0) || r == KIW'(NRND)) return r;
    case (m)
      ORD_REV: return KIW'(NRND) - r;
      ORD_ROT: return (r == KIW'(NRND - 1)) ? KIW'(1) : r + KIW'(1);
      ORD_ODD: return (r <= KIW'(NRND / 2)) ? KIW'(d - (KIW+1)'(1)) : KIW'(d - (KIW+1)'(NRND));
      default: return r;
    endcase
  endfunction
endpackage

// File: rtl/aes_round_unit.sv
module aes_round_unit import aes_iter_pkg::*; (
  input  logic [BLK-1:0] st,
  input  logic [BLK-1:0] rkey,
  output logic [BLK-1:0] mix_out,
  output logic [BLK-1:0] fin_out
);
  logic [BLK-1:0] sub_w, shf_w, mix_w;

  for (genvar i = 0; i < NB; i++) begin : g_sub
    assign sub_w[BLK-1-8*i -: 8] = sbox8(st[BLK-1-8*i -: 8]);
  end

  assign shf_w = shift_rows(sub_w);

  for (genvar c = 0; c < NCOL; c++) begin : g_mix
    assign mix_w[BLK-1-32*c -: 32] = mix_col(shf_w[BLK-1-32*c -: 32]);
  end

  assign mix_out = mix_w ^ rkey;
  assign fin_out = shf_w ^ rkey;
endmodule

// File: rtl/aes_key_mux.sv
module aes_key_mux import aes_iter_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [NRND*BLK-1:0] keys,
  input  logic [KIW-1:0]      idx,
  output logic [BLK-1:0]      key
);
  always_comb begin
    key = '0;
    for (int k = 1; k <= NRND; k++)
      if (idx == KIW'(k)) key = keys[BLK*k-1 -: BLK];
  end

  // R5: every active round addresses an existing key
  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    en |-> (idx >= KIW'(1) && idx <= KIW'(NRND)));
endmodule

// File: rtl/aes_round_seq.sv
module aes_round_seq import aes_iter_pkg::*; (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     seed,
  output logic           load,
  output logic           active,
  output logic           last,
  output logic           done,
  output logic [KIW-1:0] key_idx
);
  logic [KIW-1:0] rnd_q;   // 0 idle, 1..NRND rounds: eleven states
  ord_mode_t      mode_q;
  logic           done_q;

  assign load    = start && (rnd_q == KIW'(0));
  assign active  = (rnd_q != KIW'(0));
  assign last    = (rnd_q == KIW'(NRND));
  assign done    = done_q;
  assign key_idx = key_for(mode_q, rnd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_q  <= '0;
      mode_q <= ORD_STD;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        rnd_q  <= KIW'(1);
        mode_q <= ord_mode_t'(seed);
      end else if (active) begin
        rnd_q <= last ? KIW'(0) : rnd_q + KIW'(1);
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    last |=> done);
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (start && active && !last) |=> (rnd_q == $past(rnd_q) + KIW'(1)));
  p_mode_held_r11: assert property (@(posedge clk) disable iff (rst)
    active |=> $stable(mode_q));
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core import aes_iter_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          seed,
  input  logic [BLK-1:0]      blk_in,
  input  logic [BLK-1:0]      key_init,
  input  logic [NRND*BLK-1:0] key_rounds,
  output logic [BLK-1:0]      blk_out,
  output logic                done
);
  logic           load_w, active_w, last_w;
  logic [KIW-1:0] key_idx_w;
  logic [BLK-1:0] rkey_w, mix_w, fin_w, st_d;
  logic [BLK-1:0] st_q, res_q;

  aes_round_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .seed(seed),
    .load(load_w), .active(active_w), .last(last_w), .done(done), .key_idx(key_idx_w)
  );

  aes_key_mux u_kmux (
    .clk(clk), .rst(rst), .en(active_w), .keys(key_rounds), .idx(key_idx_w), .key(rkey_w)
  );

  aes_round_unit u_round (
    .st(st_q), .rkey(rkey_w), .mix_out(mix_w), .fin_out(fin_w)
  );

  // input selector: fresh whitened block or column-mix feedback
  assign st_d = load_w ? (blk_in ^ key_init) : mix_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      res_q <= '0;
    end else begin
      if (load_w || (active_w && !last_w)) st_q <= st_d;
      if (last_w) res_q <= fin_w;
    end
  end

  // output selector: zero until the block completes
  assign blk_out = done ? res_q : '0;

  p_out_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !done |-> (blk_out == '0));
  p_final_key_r9: assert property (@(posedge clk) disable iff (rst)
    last_w |-> (key_idx_w == KIW'(NRND)));
  p_load_whiten_r2: assert property (@(posedge clk) disable iff (rst)
    load_w |=> (st_q == $past(blk_in ^ key_init)));
endmodule

// File: tb/aes_iter_core_test.sv
module aes_iter_core_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, start;
  logic [1:0]    seed;
  logic [127:0]  blk_in, key_init;
  logic [1279:0] key_rounds;
  logic [127:0]  blk_out;
  logic          done;

  aes_iter_core uut (
    .clk(clk), .rst(rst), .start(start), .seed(seed), .blk_in(blk_in),
    .key_init(key_init), .key_rounds(key_rounds), .blk_out(blk_out), .done(done)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]   sb [0:255];
  logic [127:0] rk [0:10];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a, y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic int tb_order(input int sd, input int r);
    int t [0:8];
    case (sd)
      1: t = '{9, 8, 7, 6, 5, 4, 3, 2, 1};
      2: t = '{2, 3, 4, 5, 6, 7, 8, 9, 1};
      3: t = '{1, 3, 5, 7, 9, 2, 4, 6, 8};
      default: t = '{1, 2, 3, 4, 5, 6, 7, 8, 9};
    endcase
    return t[r-1];
  endfunction

  function automatic logic [127:0] tb_round(input logic [127:0] s, input logic [127:0] k, input bit with_mix);
    logic [7:0] b [0:15];
    logic [7:0] t [0:15];
    logic [7:0] m [0:3];
    logic [127:0] o;
    m = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int i = 0; i < 16; i++) b[i] = sb[s[127-8*i -: 8]];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) t[4*c+r] = b[4*((c+r)%4)+r];
    if (with_mix)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) begin
          logic [7:0] acc = 0;
          for (int j = 0; j < 4; j++) acc ^= gm(m[(j-r+4)%4], t[4*c+j]);
          b[4*c+r] = acc;
        end
    else
      for (int i = 0; i < 16; i++) b[i] = t[i];
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = b[i];
    return o ^ k;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] p, input int sd);
    logic [127:0] s = p ^ rk[0];
    for (int r = 1; r <= 9; r++) s = tb_round(s, rk[tb_order(sd, r)], 1'b1);
    return tb_round(s, rk[10], 1'b0);
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k <= 10; k++) rk[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    key_init = rk[0];
    for (int k = 1; k <= 10; k++) key_rounds[128*k-1 -: 128] = rk[k];
  endtask

  task automatic run(input logic [127:0] p, input int sd, input bit mid_start, input bit mid_seed,
                     output logic [127:0] got, output int lat);
    @(negedge clk);
    blk_in = p; seed = 2'(sd); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0; got = '0;
    for (int c = 1; c <= 11; c++) begin
      @(negedge clk);
      if (done && lat == 0) begin lat = c; got = blk_out; end
      else if (!done) chk(blk_out == '0, "R4 output zero while not done", blk_out, '0);
      if (c == 11) chk(!done, "R3 done lasts one cycle", {127'b0, done}, '0);
      if (mid_seed && c == 3) seed = ~seed;
      if (mid_start && c == 4) begin start = 1'b1; blk_in = ~p; seed = 2'(sd + 1); end
      if (mid_start && c == 5) start = 1'b0;
    end
    chk(lat == 10, "R2 latency ten cycles", 128'(lat), 128'd10);
  endtask

  function automatic string seed_req(input int sd);
    case (sd)
      0: return "R5 seed0 standard order";
      1: return "R6 seed1 reversed order";
      2: return "R7 seed2 rotated order";
      default: return "R8 seed3 odd-even order";
    endcase
  endfunction

  initial begin
    logic [127:0] got, got2, p;
    int lat;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0;
      for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      sb[a] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
    end
    rst = 1'b1; start = 1'b0; seed = 0; blk_in = '0; key_init = '0; key_rounds = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done, "R1 done low after reset", {127'b0, done}, '0);
    chk(blk_out == '0, "R1 output zero after reset", blk_out, '0);

    // known-answer vector, seed 0 (R5)
    expand(128'h000102030405060708090a0b0c0d0e0f);
    run(128'h00112233445566778899aabbccddeeff, 0, 0, 0, got, lat);
    chk(got == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5 known-answer vector", got,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // sweep all seeds with random blocks and keys
    for (int kk = 0; kk < 3; kk++) begin
      expand({$urandom, $urandom, $urandom, $urandom});
      for (int sd = 0; sd < 4; sd++)
        for (int n = 0; n < 3; n++) begin
          p = {$urandom, $urandom, $urandom, $urandom};
          run(p, sd, 0, 0, got, lat);
          chk(got == model(p, sd), seed_req(sd), got, model(p, sd));
        end
    end

    // non-standard seeds must differ from standard order
    p = {$urandom, $urandom, $urandom, $urandom};
    for (int sd = 1; sd < 4; sd++) begin
      run(p, sd, 0, 0, got, lat);
      chk(got != model(p, 0), seed_req(sd), got, model(p, 0));
    end

    // R9: flipping bit 0 of key 10 flips only bit 0 of the result, every seed
    for (int sd = 0; sd < 4; sd++) begin
      run(p, sd, 0, 0, got, lat);
      key_rounds[128*9] = ~key_rounds[128*9];
      run(p, sd, 0, 0, got2, lat);
      key_rounds[128*9] = ~key_rounds[128*9];
      chk((got ^ got2) == 128'd1, "R9 final round no mix, key 10", got ^ got2, 128'd1);
    end

    // R10: start while busy ignored
    for (int sd = 0; sd < 4; sd++) begin
      run(p, sd, 1, 0, got, lat);
      chk(got == model(p, sd), "R10 busy start ignored", got, model(p, sd));
    end

    // R11: seed change mid-block ignored
    for (int sd = 0; sd < 4; sd++) begin
      run(p, sd, 0, 1, got, lat);
      chk(got == model(p, sd), "R11 seed sampled at start", got, model(p, sd));
    end

    // R1: reset mid-block abandons it
    @(negedge clk);
    blk_in = p; seed = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    begin
      bit seen = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (done || blk_out != '0) seen = 1;
      end
      chk(!seen, "R1 reset abandons block", {127'b0, seen}, '0);
    end
    run(p, 2, 0, 0, got, lat);
    chk(got == model(p, 2), "R1 block after reset", got, model(p, 2));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule